// File: doc/BRIEF.md
# Load Wait Predictor Table

This block predicts which loads are likely to break memory ordering if they issue too early. It keeps one bit per entry in a small table. The table is addressed by an XOR-fold of the load's program counter. When the redirect logic reports that a load was replayed because of an ordering violation, the entry for that load's address is set. Later, at fetch or instruction-buffer time, each load looks up its entry in the same cycle. The wait bit it gets back travels with the instruction.

In the reservation station, a load whose wait bit is set is held until the store-queue issue pointer has moved past every store older than the load. This block contains only that pointer comparison, not the station itself. The issue pointer is never allowed to count as lagging behind the commit pointer. A control bit can switch prediction off. The whole table is wiped on a long fixed period, so that stale predictions age out.

Top module: `ldwait_predictor`

## Requirements
- R1: After reset every table entry is clear, so every lookup returns a wait bit of 0.
- R2: The table index bit j is the XOR of pc[1+j+k*IDX_W] for every k for which that bit exists; pc[0] is unused. Program counters that fold to the same index share one entry.
- R3: When update port p is valid with data 1 at a clock edge, the entry for upd_pc[p] reads 1 from the next cycle on. Lookups are combinational, so lk_wait reflects the table in the cycle the address is applied.
- R4: An update port with data 0 clears its entry. When several valid ports hit the same index in one cycle, the port with the lowest number wins.
- R5: Counting clock edges with rst_n high from 1, the table is wiped at edge number CLR_PERIOD and at every CLR_PERIOD edges after that. Before the wipe, entries keep their values.
- R6: An update applied at the same edge as a wipe survives it. The wipe clears all other entries.
- R7: While pred_en is 0, every lk_wait reads 0. Updates are still recorded and become visible once pred_en returns to 1.
- R8: Store-queue pointers are {wrap, index}, with the wrap bit as the top bit. rel_ok[i] is 1 when rel_wait[i] is 0. Otherwise it is 1 only when the effective issue pointer has reached rel_ptr[i]. With equal wrap bits, reached means index greater than or equal; with different wrap bits, it means index less than.
- R9: The effective issue pointer is sq_commit whenever sq_issue has not reached sq_commit under the R8 ordering; otherwise it is sq_issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_en | input | 1 | Prediction enable control bit |
| upd_v | input | UPD_N | Per-port update valid |
| upd_pc | input | UPD_N x PC_W | Per-port program counter of the replayed load |
| upd_d | input | UPD_N | Per-port value written (1 = wait) |
| lk_pc | input | LK_N x PC_W | Per-lane lookup program counter |
| lk_wait | output | LK_N | Per-lane wait bit, same cycle |
| sq_issue | input | SQ_W+1 | Store-queue issue pointer {wrap, index} |
| sq_commit | input | SQ_W+1 | Store-queue commit pointer {wrap, index} |
| rel_wait | input | RS_N | Wait bit held by each station entry |
| rel_ptr | input | RS_N x (SQ_W+1) | Store-queue position just past each load's older stores |
| rel_ok | output | RS_N | Station entry may issue |

## Verification
The periodic wipe and a violation update can land on the same clock edge. That collision decides whether a fresh prediction is lost. The bench counts edges since reset itself and drives an update so that it arrives exactly at edge CLR_PERIOD. Beforehand it confirms that an older entry is still set. Afterwards it confirms that the older entry is gone and that the new one reads 1. Two update ports hitting one index in the same cycle is the other collision. It is driven in both port orders, and the bench checks that the lower-numbered port's value wins.

// File: rtl/ldw_pkg.sv
// Shared helpers for the load wait predictor.
// Assumes store-queue pointers are split into a wrap flag and an index.
package ldw_pkg;

    // True when pointer a has reached or passed pointer b in circular order.
    function automatic logic ptr_reached(input logic wa, input logic [31:0] va,
                                         input logic wb, input logic [31:0] vb);
        if (wa == wb)
            return va >= vb;
        else
            return va < vb;
    endfunction

endpackage

// File: rtl/ldw_fold.sv
// XOR-folds a program counter into a table index.
// Assumes pc[0] carries no information (halfword-aligned instructions).
module ldw_fold #(
    parameter int PC_W  = 39,
    parameter int IDX_W = 9
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);

    // Fold bit b of the PC onto index bit (b-1) mod IDX_W.
    always_comb begin
        idx = '0;
        for (int b = 1; b < PC_W; b++) begin
            idx[(b-1) % IDX_W] = idx[(b-1) % IDX_W] ^ pc[b];
        end
    end

endmodule

// File: rtl/ldw_table.sv
// Single-bit prediction table with a periodic wipe and prioritised writes.
// Assumes CLR_PERIOD >= 2; port 0 has the highest write priority; writes win over the wipe.
module ldw_table #(
    parameter int IDX_W      = 9,
    parameter int UPD_N      = 2,
    parameter int LK_N       = 2,
    parameter int CLR_PERIOD = 131072
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [UPD_N-1:0]             upd_v,
    input  logic [UPD_N-1:0][IDX_W-1:0]  upd_idx,
    input  logic [UPD_N-1:0]             upd_d,
    input  logic [LK_N-1:0][IDX_W-1:0]   lk_idx,
    output logic [LK_N-1:0]              lk_bit
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int CW    = $clog2(CLR_PERIOD);
    localparam logic [CW-1:0] LAST = CW'(CLR_PERIOD - 1);

    logic [DEPTH-1:0] tbl;
    logic [CW-1:0]    wipe_cnt;
    logic             wipe_now;

    assign wipe_now = (wipe_cnt == LAST);

    // Count edges between wipes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wipe_cnt <= '0;
        else if (wipe_now)
            wipe_cnt <= '0;
        else
            wipe_cnt <= wipe_cnt + 1'b1;
    end

    // Apply the wipe, then the writes from lowest to highest priority (last write wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl <= '0;
        end else begin
            if (wipe_now)
                tbl <= '0;
            for (int p = UPD_N - 1; p >= 0; p--) begin
                if (upd_v[p])
                    tbl[upd_idx[p]] <= upd_d[p];
            end
        end
    end

    // Combinational read of the registered table for every lookup lane.
    always_comb begin
        for (int l = 0; l < LK_N; l++)
            lk_bit[l] = tbl[lk_idx[l]];
    end

endmodule

// File: rtl/ldw_release.sv
// Decides whether a held load may leave the reservation station.
// Assumes each held load carries the store-queue position just past its older stores.
module ldw_release
    import ldw_pkg::*;
#(
    parameter int SQ_W = 4,
    parameter int RS_N = 2
) (
    input  logic [SQ_W:0]             sq_issue,
    input  logic [SQ_W:0]             sq_commit,
    input  logic [RS_N-1:0]           rel_wait,
    input  logic [RS_N-1:0][SQ_W:0]   rel_ptr,
    output logic [RS_N-1:0]           rel_ok
);

    logic [SQ_W:0] eff_ptr;

    // Never let the issue pointer count as behind the commit pointer.
    always_comb begin
        if (ptr_reached(sq_issue[SQ_W], 32'(sq_issue[SQ_W-1:0]),
                        sq_commit[SQ_W], 32'(sq_commit[SQ_W-1:0])))
            eff_ptr = sq_issue;
        else
            eff_ptr = sq_commit;
    end

    // A flagged entry is released once the effective pointer reaches its position.
    always_comb begin
        for (int i = 0; i < RS_N; i++) begin
            rel_ok[i] = !rel_wait[i] ||
                        ptr_reached(eff_ptr[SQ_W], 32'(eff_ptr[SQ_W-1:0]),
                                    rel_ptr[i][SQ_W], 32'(rel_ptr[i][SQ_W-1:0]));
        end
    end

endmodule

// File: rtl/ldwait_predictor.sv
// Top of the load wait predictor: folds addresses, owns the table, gates output
// with the enable bit and evaluates release against the store-queue issue pointer.
// Assumes the enable bit comes from a control register in the caller's clock domain.
module ldwait_predictor #(
    parameter int PC_W       = 39,
    parameter int IDX_W      = 9,
    parameter int UPD_N      = 2,
    parameter int LK_N       = 2,
    parameter int RS_N       = 2,
    parameter int SQ_W       = 4,
    parameter int CLR_PERIOD = 131072
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pred_en,
    input  logic [UPD_N-1:0]             upd_v,
    input  logic [UPD_N-1:0][PC_W-1:0]   upd_pc,
    input  logic [UPD_N-1:0]             upd_d,
    input  logic [LK_N-1:0][PC_W-1:0]    lk_pc,
    output logic [LK_N-1:0]              lk_wait,
    input  logic [SQ_W:0]                sq_issue,
    input  logic [SQ_W:0]                sq_commit,
    input  logic [RS_N-1:0]              rel_wait,
    input  logic [RS_N-1:0][SQ_W:0]      rel_ptr,
    output logic [RS_N-1:0]              rel_ok
);

    logic [UPD_N-1:0][IDX_W-1:0] upd_idx;
    logic [LK_N-1:0][IDX_W-1:0]  lk_idx;
    logic [LK_N-1:0]             lk_bit;

    // One index fold per update port.
    for (genvar p = 0; p < UPD_N; p++) begin : g_upd_fold
        ldw_fold #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fold (
            .pc  (upd_pc[p]),
            .idx (upd_idx[p])
        );
    end

    // One index fold per lookup lane.
    for (genvar l = 0; l < LK_N; l++) begin : g_lk_fold
        ldw_fold #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fold (
            .pc  (lk_pc[l]),
            .idx (lk_idx[l])
        );
    end

    ldw_table #(
        .IDX_W(IDX_W), .UPD_N(UPD_N), .LK_N(LK_N), .CLR_PERIOD(CLR_PERIOD)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_v   (upd_v),
        .upd_idx (upd_idx),
        .upd_d   (upd_d),
        .lk_idx  (lk_idx),
        .lk_bit  (lk_bit)
    );

    // Prediction off forces every wait bit low.
    assign lk_wait = lk_bit & {LK_N{pred_en}};

    ldw_release #(.SQ_W(SQ_W), .RS_N(RS_N)) u_release (
        .sq_issue  (sq_issue),
        .sq_commit (sq_commit),
        .rel_wait  (rel_wait),
        .rel_ptr   (rel_ptr),
        .rel_ok    (rel_ok)
    );

endmodule

// File: rtl/ldwait_predictor_chk.sv
// Property checker for the load wait predictor, bound to every instance of the top.
module ldwait_predictor_chk #(
    parameter int PC_W       = 39,
    parameter int IDX_W      = 9,
    parameter int UPD_N      = 2,
    parameter int LK_N       = 2,
    parameter int RS_N       = 2,
    parameter int SQ_W       = 4,
    parameter int CLR_PERIOD = 131072
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pred_en,
    input  logic [UPD_N-1:0]             upd_v,
    input  logic [UPD_N-1:0][PC_W-1:0]   upd_pc,
    input  logic [UPD_N-1:0]             upd_d,
    input  logic [LK_N-1:0][PC_W-1:0]    lk_pc,
    input  logic [LK_N-1:0]              lk_wait,
    input  logic [SQ_W:0]                sq_issue,
    input  logic [SQ_W:0]                sq_commit,
    input  logic [RS_N-1:0]              rel_wait,
    input  logic [RS_N-1:0][SQ_W:0]      rel_ptr,
    input  logic [RS_N-1:0]              rel_ok
);

    // R1: the first cycle out of reset sees an empty table.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lk_wait == '0));

    // R3: a set from the top-priority port is visible on the next cycle.
    assert_set_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_v[0] && upd_d[0]) && pred_en &&
         (lk_pc[0] == $past(upd_pc[0]))) |-> lk_wait[0]);

    // R7: prediction off means no wait bits.
    assert_off_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_en |-> (lk_wait == '0));

    for (genvar i = 0; i < RS_N; i++) begin : g_rel
        // R8: an unflagged entry is always free to go.
        assert_nowait_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !rel_wait[i] |-> rel_ok[i]);

        // R8: a flagged entry one slot beyond the pointers is held.
        assert_ahead_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_wait[i] && (sq_issue == sq_commit) &&
             (rel_ptr[i] == sq_issue + 1'b1)) |-> !rel_ok[i]);

        // R9: reaching the commit pointer always releases.
        assert_commit_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_wait[i] && (rel_ptr[i] == sq_commit)) |-> rel_ok[i]);
    end

endmodule

bind ldwait_predictor ldwait_predictor_chk #(
    .PC_W(PC_W), .IDX_W(IDX_W), .UPD_N(UPD_N), .LK_N(LK_N),
    .RS_N(RS_N), .SQ_W(SQ_W), .CLR_PERIOD(CLR_PERIOD)
) u_chk (.*);

// File: tb/ldwait_predictor_bench.sv
// Scoreboard bench: driver tasks push expected items, a monitor compares them.
module ldwait_predictor_bench;

    localparam int PC_W = 16;
    localparam int IDX_W = 5;
    localparam int SQ_W = 3;
    localparam int PER = 1024;

    localparam logic [15:0] PCA = 16'h0040; // index 1
    localparam logic [15:0] PCB = 16'h0004; // index 2
    localparam logic [15:0] PCC = 16'h0802; // index 0 (bits cancel)
    localparam logic [15:0] PCD = 16'h0008; // index 4

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pred_en = 1'b1;
    logic [1:0] upd_v = '0;
    logic [1:0][PC_W-1:0] upd_pc = '0;
    logic [1:0] upd_d = '0;
    logic [1:0][PC_W-1:0] lk_pc = '0;
    logic [1:0] lk_wait;
    logic [SQ_W:0] sq_issue = '0;
    logic [SQ_W:0] sq_commit = '0;
    logic [1:0] rel_wait = '0;
    logic [1:0][SQ_W:0] rel_ptr = '0;
    logic [1:0] rel_ok;

    int checks = 0;
    int fails = 0;
    int edges = 0;

    typedef struct {
        string     tag;
        logic [1:0] lk;
        logic [1:0] rel;
    } item_t;
    item_t sb[$];
    event ev_s;

    always #10 clk = ~clk;

    ldwait_predictor #(
        .PC_W(PC_W), .IDX_W(IDX_W), .UPD_N(2), .LK_N(2), .RS_N(2),
        .SQ_W(SQ_W), .CLR_PERIOD(PER)
    ) u_ldwait_predictor (
        .clk(clk), .rst_n(rst_n), .pred_en(pred_en),
        .upd_v(upd_v), .upd_pc(upd_pc), .upd_d(upd_d),
        .lk_pc(lk_pc), .lk_wait(lk_wait),
        .sq_issue(sq_issue), .sq_commit(sq_commit),
        .rel_wait(rel_wait), .rel_ptr(rel_ptr), .rel_ok(rel_ok)
    );

    // Edges since reset release, numbered from 1.
    always @(posedge clk) edges <= rst_n ? edges + 1 : 0;

    // Monitor: pop each expected item and compare with the outputs.
    always begin
        @(ev_s);
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks += 2;
            if (lk_wait !== it.lk) begin
                fails++;
                $display("FAIL %s lk_wait actual=%b expected=%b", it.tag, lk_wait, it.lk);
            end
            if (rel_ok !== it.rel) begin
                fails++;
                $display("FAIL %s rel_ok actual=%b expected=%b", it.tag, rel_ok, it.rel);
            end
        end
    end

    task automatic expect_now(input string tag, input logic [1:0] elk, input logic [1:0] erel);
        #5;
        sb.push_back('{tag, elk, erel});
        -> ev_s;
        #1;
    endtask

    task automatic look(input logic [15:0] p0, input logic [15:0] p1,
                        input logic [1:0] elk, input string tag);
        @(negedge clk);
        lk_pc[0] = p0;
        lk_pc[1] = p1;
        expect_now(tag, elk, 2'b11);
    endtask

    task automatic write2(input logic v0, input logic [15:0] p0, input logic d0,
                          input logic v1, input logic [15:0] p1, input logic d1);
        @(negedge clk);
        upd_v = {v1, v0};
        upd_pc[0] = p0; upd_pc[1] = p1;
        upd_d = {d1, d0};
        @(negedge clk);
        upd_v = '0;
    endtask

    task automatic rel(input logic [3:0] iss, input logic [3:0] cmt,
                       input logic [1:0] w, input logic [3:0] p0, input logic [3:0] p1,
                       input logic [1:0] erel, input string tag);
        @(negedge clk);
        lk_pc[0] = PCC; lk_pc[1] = PCC;
        sq_issue = iss; sq_commit = cmt;
        rel_wait = w; rel_ptr[0] = p0; rel_ptr[1] = p1;
        expect_now(tag, 2'b00, erel);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty table after reset
        lk_pc[0] = PCA; lk_pc[1] = PCB;
        expect_now("R1 reset clear", 2'b00, 2'b11);

        // R3: violation sets the entry, lane 0 reads it
        write2(1'b1, PCA, 1'b1, 1'b0, 16'h0, 1'b0);
        expect_now("R3 set visible", 2'b01, 2'b11);

        // R2: aliases of index 1 and a fold that cancels to index 0
        look(16'h0002, 16'h0842, 2'b11, "R2 alias same entry");
        look(PCC, PCB, 2'b00, "R2 cancelled fold");

        // R4: port 0 clears, port 1 sets the same index -> clear wins
        write2(1'b1, PCB, 1'b0, 1'b1, 16'h0080, 1'b1);
        look(PCB, 16'h1000, 2'b00, "R4 port0 clear wins");
        write2(1'b1, 16'h1000, 1'b1, 1'b1, PCB, 1'b0);
        look(PCB, 16'h0080, 2'b11, "R4 port0 set wins");
        write2(1'b1, PCB, 1'b0, 1'b0, 16'h0, 1'b0);
        look(PCA, PCB, 2'b01, "R4 single clear");

        // R7: disabled reads zero, updates still recorded
        @(negedge clk);
        pred_en = 1'b0;
        write2(1'b0, 16'h0, 1'b0, 1'b1, PCB, 1'b1);
        look(PCA, PCB, 2'b00, "R7 disabled zero");
        @(negedge clk);
        pred_en = 1'b1;
        expect_now("R7 reenabled shows updates", 2'b11, 2'b11);

        // R8: release ordering
        rel(4'd3, 4'd3, 2'b01, 4'd5, 4'd0, 2'b10, "R8 behind held");
        rel(4'd5, 4'd5, 2'b11, 4'd5, 4'd6, 2'b01, "R8 equal released");
        rel(4'd6, 4'd6, 2'b11, 4'd5, 4'd2, 2'b11, "R8 past released");
        rel(4'd9, 4'd9, 2'b11, 4'd6, 4'd10, 2'b01, "R8 wrap past");
        rel(4'd6, 4'd6, 2'b11, 4'd9, 4'd7, 2'b00, "R8 wrap behind");

        // R9: commit pointer floors the issue pointer
        rel(4'd2, 4'd5, 2'b11, 4'd4, 4'd6, 2'b01, "R9 commit floor");
        rel(4'd2, 4'd2, 2'b11, 4'd4, 4'd2, 2'b10, "R9 no floor");
        rel(4'd14, 4'd1, 2'b11, 4'd0, 4'd2, 2'b01, "R9 floor across wrap");
        @(negedge clk);
        rel_wait = '0;

        // R5 and R6: table intact before the wipe; an update at the wipe edge survives
        while (edges != PER - 1) @(negedge clk);
        lk_pc[0] = PCA; lk_pc[1] = PCB;
        upd_v = 2'b01; upd_pc[0] = PCD; upd_d = 2'b01;
        expect_now("R5 before wipe", 2'b11, 2'b11);
        @(negedge clk);
        upd_v = '0;
        lk_pc[0] = PCA; lk_pc[1] = PCD;
        expect_now("R6 update survives wipe", 2'b10, 2'b11);
        look(PCB, PCC, 2'b00, "R5 wiped entries");

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule